// File: doc/BRIEF.md
# Flash Bus Control and Reset Sequencer

This block is the control front end of a parallel NOR-style flash device. It watches the active-low chip enable, output enable, write enable and device reset pins. From them it works out the current device mode: read, output disabled, standby, write or deep power-down. It drives the tri-state enable of the data bus, a read-data-valid flag and a ready/busy line. The storage array and the erase and program algorithms sit outside it. An embedded operation is started through a one-cycle start pulse and ends when the outside logic returns a done pulse.

Command writes are latched when write enable rises while chip enable is low. A command either picks the read mode (array, identifier or status) or starts an embedded erase or program. The reset pin has two more roles. A long enough low pulse enters deep power-down, and it also aborts any operation that is running. After the pin rises again, two separate counters hold off read data and new commands. A separate power-on reset input brings the block to its power-up state. All pins are taken as synchronous to `clk`.

Top module: `flash_fe_ctl`

## Requirements
- R1: `dq_oe` is 1 exactly when ce_n=0, oe_n=0, we_n=1, rst_n=1 and `pd`=0, in the same cycle as the pins. `dev_mode` encodes 0 power-down, 1 standby, 2 output disabled, 3 read and 4 write.
- R2: With oe_n=1 the outputs are disabled (`dq_oe`=0, `dev_mode`=2). With ce_n=1 the device is in standby (`dev_mode`=1, `dq_oe`=0), whatever oe_n is.
- R3: A command is captured at the first clock edge that sees we_n=1 after an edge that saw we_n=0, provided ce_n=0 at that edge. Code 0xFF selects array mode (`rd_mode`=0), 0x90 selects identifier mode (1) and 0x70 selects status mode (2). Any other non-operation code is ignored, and so is a write enable rise while ce_n=1.
- R4: Code 0x20 or 0x40, when no operation is running, gives a one-cycle `op_start` pulse, drives `ry_by` to 0 and sets `rd_mode` to 2. `op_done` ends the operation. Every command captured while an operation runs is ignored.
- R5: Taking ce_n high while an operation runs does not stop it: `ry_by` stays 0 until `op_done`.
- R6: A low pulse on rst_n that lasts fewer than MIN_LO_CYC consecutive clock edges is ignored. `pd` stays 0, and the read mode and any running operation are kept.
- R7: rst_n low for MIN_LO_CYC consecutive edges sets `pd`=1 after the last of those edges. At that point `dq_oe`=0, `dev_mode`=0 and `rd_mode`=0 (array).
- R8: If an operation is running when `pd` rises, `op_abort` pulses for one cycle. `ry_by` then stays 0 through power-down and wake-up, and returns to 1 one edge after the wake-up interval ends. `status` bit 7 equals `ry_by` and the other status bits are 0, so the settled status is 0x80.
- R9: Call the first edge with rst_n=1 after power-down the exit edge X. `rd_valid` is 0 after edges X to X+WAKE_CYC-1, and after that it equals `dq_oe`.
- R10: After power-down, a command whose capture edge is X+k is accepted only if k > REC_CYC. Earlier captures are ignored.
- R11: While por_n=0 and after it is released, `rd_mode`=0, `status`=0x80, `ry_by`=1, `pd`=0 and no delay is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| rst_n | input | 1 | Device reset / power-down pin, active low |
| din | input | 8 | Command byte from the data bus |
| op_done | input | 1 | Embedded operation finished |
| dq_oe | output | 1 | Data bus drive enable |
| rd_valid | output | 1 | Read data may be used |
| dev_mode | output | 3 | Decoded device mode |
| rd_mode | output | 2 | Current read mode |
| status | output | 8 | Status register value |
| ry_by | output | 1 | Ready (1) / busy (0) |
| pd | output | 1 | Deep power-down active |
| op_start | output | 1 | One-cycle start of an embedded operation |
| op_abort | output | 1 | One-cycle abort of an embedded operation |

## Verification
The pin decode (`dq_oe`, `dev_mode`, `rd_valid`) is combinational, so it changes in the same cycle as the pins. Mode, busy, power-down and the abort and start pulses change at the edge that samples the stimulus. The ready line returns one edge after the wake-up count ends. The driver changes pins at the falling clock edge and queues the values it expects. The monitor checks them a quarter period after the next rising edge. The wake-up and recovery checks count edges from the exit edge, one queued item per edge, so a delay that is off by one is caught.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        DM_PWRDN   = 3'd0,
        DM_STANDBY = 3'd1,
        DM_OUTDIS  = 3'd2,
        DM_READ    = 3'd3,
        DM_WRITE   = 3'd4
    } dev_mode_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_PROG   = 8'h40;

endpackage

// File: rtl/flash_fe_rstseq.sv
// Reset-pin sequencer: pulse-width filter, power-down state,
// wake-up and command-recovery counters.
module flash_fe_rstseq #(
    parameter int MIN_LO_CYC = 4,
    parameter int WAKE_CYC   = 6,
    parameter int REC_CYC    = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    output logic pd,
    output logic pd_enter,
    output logic wake_done,
    output logic cmd_ready
);
    localparam int LO_W = $clog2(MIN_LO_CYC + 2);
    localparam int WK_W = $clog2(WAKE_CYC + 2);
    localparam int RC_W = $clog2(REC_CYC + 2);
    localparam logic [LO_W-1:0] LO_LAST  = LO_W'(MIN_LO_CYC - 1);
    localparam logic [WK_W-1:0] WAKE_LD  = WK_W'(WAKE_CYC);
    localparam logic [RC_W-1:0] REC_LD   = RC_W'(REC_CYC);

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            pd;
        logic [WK_W-1:0] wake;
        logic [RC_W-1:0] rec;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        pd_enter = 1'b0;
        if (!rst_n) begin
            if (!seq_q.pd) begin
                if (seq_q.lo == LO_LAST) begin
                    seq_d.pd = 1'b1;
                    seq_d.lo = '0;
                    pd_enter = 1'b1;
                end else begin
                    seq_d.lo = seq_q.lo + 1'b1;
                end
            end
        end else begin
            seq_d.lo = '0;
            if (seq_q.pd) begin
                seq_d.pd   = 1'b0;
                seq_d.wake = WAKE_LD;
                seq_d.rec  = REC_LD;
            end else begin
                if (seq_q.wake != '0) seq_d.wake = seq_q.wake - 1'b1;
                if (seq_q.rec  != '0) seq_d.rec  = seq_q.rec  - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pd        = seq_q.pd;
    assign wake_done = !seq_q.pd && (seq_q.wake == '0);
    assign cmd_ready = rst_n && !seq_q.pd && (seq_q.rec == '0);

endmodule

// File: rtl/flash_fe_cmdctl.sv
// Command capture, read mode, embedded-operation busy and abort hold.
module flash_fe_cmdctl
    import flash_fe_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic [7:0] din,
    input  logic       cmd_ready,
    input  logic       pd_enter,
    input  logic       wake_done,
    input  logic       op_done,
    output logic [1:0] rd_mode,
    output logic       ry_by,
    output logic       op_start,
    output logic       op_abort,
    output logic [7:0] status
);
    typedef struct packed {
        logic     we_prev;
        rd_mode_e mode;
        logic     busy;
        logic     hold;
        logic     start;
        logic     abort;
    } ctl_t;

    localparam ctl_t CTL_RST = '{we_prev: 1'b1, mode: RM_ARRAY, busy: 1'b0,
                                 hold: 1'b0, start: 1'b0, abort: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic capture;
    logic accept;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.start   = 1'b0;
        ctl_d.abort   = 1'b0;
        ctl_d.we_prev = we_n;
        capture       = we_n && !ctl_q.we_prev && !ce_n;
        accept        = capture && cmd_ready && !ctl_q.busy && !ctl_q.hold;
        if (pd_enter) begin
            ctl_d.mode  = RM_ARRAY;
            ctl_d.busy  = 1'b0;
            ctl_d.hold  = ctl_q.busy;
            ctl_d.abort = ctl_q.busy;
        end else begin
            if (ctl_q.busy && op_done)   ctl_d.busy = 1'b0;
            if (ctl_q.hold && wake_done) ctl_d.hold = 1'b0;
            if (accept) begin
                case (din)
                    CMD_ARRAY:  ctl_d.mode = RM_ARRAY;
                    CMD_IDENT:  ctl_d.mode = RM_IDENT;
                    CMD_STATUS: ctl_d.mode = RM_STATUS;
                    CMD_ERASE, CMD_PROG: begin
                        ctl_d.mode  = RM_STATUS;
                        ctl_d.busy  = 1'b1;
                        ctl_d.start = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rd_mode  = ctl_q.mode;
    assign ry_by    = !(ctl_q.busy || ctl_q.hold);
    assign op_start = ctl_q.start;
    assign op_abort = ctl_q.abort;
    assign status   = {ry_by, 7'b0};

endmodule

// File: rtl/flash_fe_busdec.sv
// Pin decode: device mode, bus drive enable and read validity.
module flash_fe_busdec
    import flash_fe_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       rst_n,
    input  logic       pd,
    input  logic       wake_done,
    output logic       dq_oe,
    output logic       rd_valid,
    output logic [2:0] dev_mode
);
    dev_mode_e mode;

    always_comb begin
        if (!rst_n || pd)  mode = DM_PWRDN;
        else if (ce_n)     mode = DM_STANDBY;
        else if (!we_n)    mode = DM_WRITE;
        else if (oe_n)     mode = DM_OUTDIS;
        else               mode = DM_READ;
    end

    assign dev_mode = mode;
    assign dq_oe    = (mode == DM_READ);
    assign rd_valid = dq_oe && wake_done;

endmodule

// File: rtl/flash_fe_ctl.sv
module flash_fe_ctl #(
    parameter int MIN_LO_CYC = 4,
    parameter int WAKE_CYC   = 6,
    parameter int REC_CYC    = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       rst_n,
    input  logic [7:0] din,
    input  logic       op_done,
    output logic       dq_oe,
    output logic       rd_valid,
    output logic [2:0] dev_mode,
    output logic [1:0] rd_mode,
    output logic [7:0] status,
    output logic       ry_by,
    output logic       pd,
    output logic       op_start,
    output logic       op_abort
);
    logic pd_enter;
    logic wake_done;
    logic cmd_ready;

    flash_fe_rstseq #(
        .MIN_LO_CYC (MIN_LO_CYC),
        .WAKE_CYC   (WAKE_CYC),
        .REC_CYC    (REC_CYC)
    ) u_rstseq (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .pd        (pd),
        .pd_enter  (pd_enter),
        .wake_done (wake_done),
        .cmd_ready (cmd_ready)
    );

    flash_fe_cmdctl u_cmdctl (
        .clk       (clk),
        .por_n     (por_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .din       (din),
        .cmd_ready (cmd_ready),
        .pd_enter  (pd_enter),
        .wake_done (wake_done),
        .op_done   (op_done),
        .rd_mode   (rd_mode),
        .ry_by     (ry_by),
        .op_start  (op_start),
        .op_abort  (op_abort),
        .status    (status)
    );

    flash_fe_busdec u_busdec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rst_n     (rst_n),
        .pd        (pd),
        .wake_done (wake_done),
        .dq_oe     (dq_oe),
        .rd_valid  (rd_valid),
        .dev_mode  (dev_mode)
    );

endmodule

// File: rtl/flash_fe_ctl_chk.sv
module flash_fe_ctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       dq_oe,
    input logic       pd,
    input logic       ry_by,
    input logic [1:0] rd_mode,
    input logic       op_start,
    input logic       op_abort
);
    // R1: the bus is driven only under the full pin condition
    a_r1_oe_pins: assert property (@(posedge clk) disable iff (!por_n)
        dq_oe |-> (!ce_n && !oe_n && we_n && rst_n));

    // R7: power-down only follows a low reset pin
    a_r7_pd_needs_low: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pd) |-> !$past(rst_n));

    // R7: read mode is array while powered down
    a_r7_mode_array: assert property (@(posedge clk) disable iff (!por_n)
        pd |-> (rd_mode == 2'd0));

    // R4: a started operation shows busy
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!por_n)
        op_start |-> !ry_by);

    // R8: an abort comes with power-down and busy held
    a_r8_abort_busy: assert property (@(posedge clk) disable iff (!por_n)
        op_abort |-> (pd && !ry_by));
endmodule

bind flash_fe_ctl flash_fe_ctl_chk u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_oe    (dq_oe),
    .pd       (pd),
    .ry_by    (ry_by),
    .rd_mode  (rd_mode),
    .op_start (op_start),
    .op_abort (op_abort)
);

// File: tb/flash_fe_ctl_test.sv
module flash_fe_ctl_test;
    localparam int CLK_P = 10;
    localparam int MINL  = 4;
    localparam int WAKE  = 6;
    localparam int REC   = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rst_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic op_done = 1'b0;
    logic dq_oe, rd_valid, ry_by, pd, op_start, op_abort;
    logic [2:0] dev_mode;
    logic [1:0] rd_mode;
    logic [7:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        string req;
        int    sig;
        int    val;
    } exp_t;
    exp_t exq[$];

    localparam int S_OE = 0, S_DEV = 1, S_RM = 2, S_RB = 3, S_ST = 4,
                   S_PD = 5, S_RV = 6, S_START = 7, S_ABORT = 8;

    always #(CLK_P/2) clk = ~clk;

    flash_fe_ctl #(.MIN_LO_CYC(MINL), .WAKE_CYC(WAKE), .REC_CYC(REC)) uut (
        .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rst_n(rst_n), .din(din), .op_done(op_done), .dq_oe(dq_oe),
        .rd_valid(rd_valid), .dev_mode(dev_mode), .rd_mode(rd_mode),
        .status(status), .ry_by(ry_by), .pd(pd), .op_start(op_start),
        .op_abort(op_abort)
    );

    function automatic int actual(int s);
        case (s)
            S_OE:    return int'(dq_oe);
            S_DEV:   return int'(dev_mode);
            S_RM:    return int'(rd_mode);
            S_RB:    return int'(ry_by);
            S_ST:    return int'(status);
            S_PD:    return int'(pd);
            S_RV:    return int'(rd_valid);
            S_START: return int'(op_start);
            default: return int'(op_abort);
        endcase
    endfunction

    function automatic string sname(int s);
        case (s)
            S_OE: return "dq_oe";     S_DEV: return "dev_mode";
            S_RM: return "rd_mode";   S_RB:  return "ry_by";
            S_ST: return "status";    S_PD:  return "pd";
            S_RV: return "rd_valid";  S_START: return "op_start";
            default: return "op_abort";
        endcase
    endfunction

    // monitor: compare queued expectations after each rising edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        while (exq.size() > 0) begin
            exp_t e;
            int a;
            e = exq.pop_front();
            a = actual(e.sig);
            n_tests++;
            if (a != e.val) begin
                n_fail++;
                $display("FAIL %s %s got %0d expected %0d", e.req, sname(e.sig), a, e.val);
            end
        end
    end

    task automatic chk(string r, int s, int v);
        exq.push_back('{req: r, sig: s, val: v});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_pins(logic c, logic o, logic w, logic r);
        ce_n = c; oe_n = o; we_n = w; rst_n = r;
    endtask

    // leaves we_n rising at a falling edge; next rising edge captures
    task automatic wr_cmd(logic [7:0] c, logic cen);
        ce_n = cen; oe_n = 1'b1; din = c; we_n = 1'b0;
        tick();
        we_n = 1'b1;
    endtask

    initial begin
        repeat (3) tick();
        por_n = 1'b1;
        chk("R11", S_RM, 0); chk("R11", S_ST, 8'h80); chk("R11", S_RB, 1);
        chk("R11", S_PD, 0); chk("R2", S_DEV, 1);     chk("R2", S_OE, 0);
        tick();

        set_pins(0, 0, 1, 1);
        chk("R1", S_OE, 1); chk("R1", S_DEV, 3); chk("R9", S_RV, 1);
        tick();
        set_pins(0, 1, 1, 1);
        chk("R2", S_OE, 0); chk("R2", S_DEV, 2);
        tick();
        set_pins(1, 0, 1, 1);
        chk("R2", S_OE, 0); chk("R2", S_DEV, 1);
        tick();
        set_pins(0, 0, 0, 1);
        chk("R1", S_OE, 0); chk("R1", S_DEV, 4);
        tick();
        set_pins(1, 1, 1, 1);
        tick();

        wr_cmd(8'h90, 1'b0); chk("R3", S_RM, 1); tick(); ce_n = 1'b1;
        wr_cmd(8'h70, 1'b0); chk("R3", S_RM, 2); tick(); ce_n = 1'b1;
        wr_cmd(8'h55, 1'b0); chk("R3", S_RM, 2); tick(); ce_n = 1'b1;
        wr_cmd(8'h90, 1'b1); chk("R3", S_RM, 2); tick(); ce_n = 1'b1;
        wr_cmd(8'hFF, 1'b0); chk("R3", S_RM, 0); tick(); ce_n = 1'b1;

        wr_cmd(8'h20, 1'b0);
        chk("R4", S_START, 1); chk("R4", S_RB, 0); chk("R4", S_RM, 2); chk("R8", S_ST, 0);
        tick(); ce_n = 1'b1;
        chk("R4", S_START, 0);
        tick();
        wr_cmd(8'hFF, 1'b0); chk("R4", S_RM, 2); tick(); ce_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk("R5", S_RB, 0);
            tick();
        end

        rst_n = 1'b0;
        for (int i = 0; i < MINL - 1; i++) begin
            chk("R6", S_PD, 0);
            tick();
        end
        rst_n = 1'b1;
        chk("R6", S_PD, 0); chk("R6", S_RB, 0); chk("R6", S_RM, 2);
        tick();
        op_done = 1'b1;
        chk("R4", S_RB, 1); chk("R8", S_ST, 8'h80);
        tick();
        op_done = 1'b0;

        wr_cmd(8'h40, 1'b0); chk("R4", S_START, 1); tick();
        set_pins(0, 0, 1, 1);
        tick();
        rst_n = 1'b0;
        for (int i = 0; i < MINL - 1; i++) begin
            chk("R7", S_PD, 0); chk("R7", S_OE, 0);
            tick();
        end
        chk("R7", S_PD, 1); chk("R8", S_ABORT, 1); chk("R8", S_RB, 0);
        chk("R7", S_RM, 0); chk("R7", S_DEV, 0);
        tick();
        chk("R8", S_ABORT, 0); chk("R7", S_PD, 1); chk("R8", S_ST, 0);
        tick();
        rst_n = 1'b1;
        chk("R9", S_PD, 0); chk("R9", S_RV, 0); chk("R1", S_OE, 1); chk("R8", S_RB, 0);
        tick();
        for (int k = 1; k < WAKE; k++) begin
            chk("R9", S_RV, 0);
            tick();
        end
        chk("R9", S_RV, 1); chk("R8", S_RB, 0);
        tick();
        chk("R8", S_RB, 1); chk("R8", S_ST, 8'h80);
        tick();

        rst_n = 1'b0;
        for (int i = 0; i < MINL - 1; i++) tick();
        chk("R7", S_PD, 1); chk("R8", S_RB, 1);
        tick();
        rst_n = 1'b1;
        tick();
        oe_n = 1'b1; din = 8'h90; we_n = 1'b0;
        tick();
        we_n = 1'b1;
        chk("R10", S_RM, 0);
        tick();
        we_n = 1'b0;
        tick();
        we_n = 1'b1;
        chk("R10", S_RM, 1);
        tick();
        ce_n = 1'b1;
        tick();
        tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog run did not complete got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule